// File: doc/BRIEF.md
# Multicycle Byte-Register Processor

This block is a small processor core built around sixteen 8-bit general registers, an 8-bit program counter and a 16-bit instruction register. It talks to a 256-byte memory over one synchronous port: an address, a write strobe and write data go out, and read data comes back one clock after the address was presented. Every instruction is two bytes long. The upper nibble selects the operation and the remaining twelve bits carry register numbers, an address or a constant.

The core runs a fixed state sequence. `ST_FETCH_HI` presents PC. `ST_FETCH_LO` presents PC+1 and captures the upper instruction byte. `ST_DECODE` captures the lower byte and advances PC by two. `ST_EXEC` carries out the operation. The core then returns to `ST_FETCH_HI`, except in two cases: a memory load passes through `ST_LOAD_WB`, where the returned byte is written to the register file, and a halt goes to `ST_HALT`, which it never leaves until reset. The operations are memory load, constant load, store, register copy, wrapping integer add, an 8-bit floating-point add (done in its own submodule), OR, AND, XOR, rotate-right by an immediate count, a jump taken when a register equals register 0, and halt.

Top module: `bytecpu_core`

## Requirements
- R1: The first instruction byte (opcode in bits 15:12) is read from address PC in `ST_FETCH_HI` and the second from PC+1 in `ST_FETCH_LO`. PC has grown by two when `ST_EXEC` is entered. A non-load instruction takes four cycles and a load (opcode 1) takes five.
- R2: While reset is low and in the first cycle after it, the core has PC = 00, every register = 00, `halted` low, `mem_wr` low and `mem_addr` = 00.
- R3: Opcode 1 (bits 11:8 = register, 7:0 = address) loads the register from memory. Opcode 2 loads the register with bits 7:0. Opcode 3 drives `mem_addr` = bits 7:0, `mem_wdata` = the register and `mem_wr` high for exactly the one `ST_EXEC` cycle.
- R4: Opcode 4 copies the register named in bits 7:4 into the register named in bits 3:0. Bits 11:8 have no effect.
- R5: Opcode 5 writes (reg[bits 7:4] + reg[bits 3:0]) mod 256 into reg[bits 11:8]. No carry is kept.
- R6: Opcode 6 adds reg[7:4] and reg[3:0] as floats and writes the result into reg[11:8]. A float is sign in bit 7, exponent in bits 6:4 with bias 4, and fraction in bits 3:0 with a hidden leading one. The patterns 00 and 80 mean zero. The exact sum is truncated toward zero to five significant bits. A magnitude above 1.1111b×2^3 saturates to exponent 7 and fraction F with the sum's sign. A magnitude below 1.0001b×2^-4 gives 00.
- R7: Opcodes 7, 8 and 9 write the OR, AND and XOR of reg[7:4] and reg[3:0] into reg[11:8].
- R8: Opcode A rotates reg[11:8] right by bits 3:0 positions. The bit leaving bit 0 re-enters at bit 7, so counts 0 and 8 leave the value unchanged.
- R9: Opcode B loads PC with bits 7:0 when reg[11:8] equals register 0, and otherwise leaves PC pointing at the next instruction. With bits 11:8 = 0 the jump is always taken.
- R10: Opcode C, whatever its operand, moves the core to `ST_HALT`. There `halted` stays high, `mem_wr` stays low and `mem_addr` holds the address after the halt instruction.
- R11: Opcodes 0, D, E and F change no register and no memory byte.
- R12: A store that writes the instruction bytes fetched right after it makes the core execute the newly written instruction. A register written by one instruction is seen by the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Memory address for the current cycle |
| mem_wr | output | 1 | Write strobe for the memory port |
| mem_wdata | output | 8 | Byte to be written when `mem_wr` is high |
| mem_rdata | input | 8 | Byte read from the address presented in the previous cycle |
| halted | output | 1 | High while the core is stopped by a halt instruction |

## Verification
Two activities can fall on the same memory location in back-to-back cycles. A store executes in `ST_EXEC`, and the very next cycle, `ST_FETCH_HI`, presents the address of the following instruction. A program that stores into that following instruction provokes this collision: it rewrites a constant-load into a halt. The run is judged by whether the core stops there with a halt address of 0A and never performs the store that would otherwise come next. A behavioural reference model predicts the address, strobe, data and halted outputs for every clock. It is compared against the core through fixed programs covering each opcode, the rotate and float corner cases, and a pseudo-random program.

// File: rtl/bytecpu_pkg.sv
package bytecpu_pkg;

    typedef enum logic [3:0] {
        OP_NOP0 = 4'h0,
        OP_LDM  = 4'h1,
        OP_LDI  = 4'h2,
        OP_STM  = 4'h3,
        OP_MOV  = 4'h4,
        OP_ADDI = 4'h5,
        OP_ADDF = 4'h6,
        OP_OR   = 4'h7,
        OP_AND  = 4'h8,
        OP_XOR  = 4'h9,
        OP_ROR  = 4'hA,
        OP_JEQ  = 4'hB,
        OP_HALT = 4'hC,
        OP_NOPD = 4'hD,
        OP_NOPE = 4'hE,
        OP_NOPF = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH_HI = 3'd0,
        ST_FETCH_LO = 3'd1,
        ST_DECODE   = 3'd2,
        ST_EXEC     = 3'd3,
        ST_LOAD_WB  = 3'd4,
        ST_HALT     = 3'd5
    } cpu_state_e;

endpackage

// File: rtl/bytecpu_regfile.sv
module bytecpu_regfile #(
    parameter int DATA_W = 8,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    input  logic [IDX_W-1:0]  raddr_b,
    input  logic [IDX_W-1:0]  raddr_c,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b,
    output logic [DATA_W-1:0] rdata_c
);

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (we && waddr == IDX_W'(g))
                q <= wdata;
        end
        assign regs[g] = q;
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
    assign rdata_c = regs[raddr_c];

    // a written value is visible to the following instruction
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(waddr)] == $past(wdata)))
        else $error("register write lost"); // R12

endmodule

// File: rtl/bytecpu_fpadd.sv
module bytecpu_fpadd #(
    parameter int EXP_W = 3,
    parameter int MAN_W = 4
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    output logic [EXP_W+MAN_W:0] y
);

    localparam int EMAX  = (1 << EXP_W) - 1;
    localparam int FIX_W = MAN_W + 1 + EMAX;   // widest exact operand
    localparam int SUM_W = FIX_W + 2;          // signed sum
    localparam int MAG_W = FIX_W + 1;          // sum magnitude
    localparam int TOP   = EXP_W + MAN_W;

    // exact scaled integer: significand shifted by the biased exponent
    function automatic logic signed [SUM_W-1:0] to_fixed(input logic [TOP:0] v);
        logic [FIX_W-1:0] f;
        if (v[TOP-1:0] == '0)
            f = '0;
        else
            f = FIX_W'({1'b1, v[MAN_W-1:0]}) << v[TOP-1:MAN_W];
        to_fixed = v[TOP] ? -$signed({2'b00, f}) : $signed({2'b00, f});
    endfunction

    logic signed [SUM_W-1:0] sum;
    logic [MAG_W-1:0]        mag;
    logic [MAG_W-1:0]        shifted;
    logic                    neg;
    logic                    any;
    int                      lead;

    always_comb begin
        sum     = to_fixed(a) + to_fixed(b);
        neg     = sum[SUM_W-1];
        mag     = neg ? MAG_W'(-sum) : MAG_W'(sum);
        shifted = '0;
        lead    = 0;
        any     = 1'b0;
        for (int i = 0; i < MAG_W; i++) begin
            if (mag[i]) begin
                lead = i;
                any  = 1'b1;
            end
        end
        y = '0;
        if (any && lead >= MAN_W) begin
            if (lead - MAN_W > EMAX) begin
                y = {neg, EXP_W'(EMAX), {MAN_W{1'b1}}};
            end else begin
                shifted = mag >> (lead - MAN_W);
                y = {neg, EXP_W'(lead - MAN_W), shifted[MAN_W-1:0]};
            end
            if (y[TOP-1:0] == '0)
                y = '0;
        end
    end

endmodule

// File: rtl/bytecpu_alu.sv
module bytecpu_alu
    import bytecpu_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int FP_EXP_W = 3,
    localparam int FP_MAN_W = DATA_W - 1 - FP_EXP_W,
    localparam int ROT_W    = $clog2(DATA_W)
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    input  logic [DATA_W-1:0] c_val,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] fp_y
);

    logic [2*DATA_W-1:0] dbl;
    logic [ROT_W-1:0]    amt;

    bytecpu_fpadd #(
        .EXP_W (FP_EXP_W),
        .MAN_W (FP_MAN_W)
    ) u_fpadd (
        .a (b_val),
        .b (c_val),
        .y (fp_y)
    );

    always_comb begin
        amt = imm[ROT_W-1:0];
        dbl = {a_val, a_val} >> amt;
        y   = '0;
        unique case (op)
            OP_LDI:  y = imm;
            OP_MOV:  y = a_val;
            OP_ADDI: y = b_val + c_val;
            OP_ADDF: y = fp_y;
            OP_OR:   y = b_val | c_val;
            OP_AND:  y = b_val & c_val;
            OP_XOR:  y = b_val ^ c_val;
            OP_ROR:  y = dbl[DATA_W-1:0];
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/bytecpu_core.sv
module bytecpu_core
    import bytecpu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG),
    localparam int INS_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);

    cpu_state_e        state, state_nxt;
    logic [ADDR_W-1:0] pc;
    logic [INS_W-1:0]  ir;
    opcode_e           op;

    logic [IDX_W-1:0]  f_r, f_s, f_t;
    logic [IDX_W-1:0]  ra_a, ra_b, ra_c;
    logic [DATA_W-1:0] rd_a, rd_b, rd_c;
    logic [DATA_W-1:0] imm;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] alu_y, fp_sum;
    logic              jump_take;

    assign op  = opcode_e'(ir[INS_W-1 -: 4]);
    assign f_r = IDX_W'(ir[11:8]);
    assign f_s = IDX_W'(ir[7:4]);
    assign f_t = IDX_W'(ir[3:0]);
    assign imm = ir[DATA_W-1:0];

    // register read selection per operand layout
    assign ra_a = (op == OP_MOV) ? f_s : f_r;
    assign ra_b = f_s;
    assign ra_c = (op == OP_JEQ) ? '0 : f_t;

    bytecpu_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (ra_a),
        .raddr_b (ra_b),
        .raddr_c (ra_c),
        .rdata_a (rd_a),
        .rdata_b (rd_b),
        .rdata_c (rd_c)
    );

    bytecpu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op    (op),
        .a_val (rd_a),
        .b_val (rd_b),
        .c_val (rd_c),
        .imm   (imm),
        .y     (alu_y),
        .fp_y  (fp_sum)
    );

    assign jump_take = (op == OP_JEQ) && (rd_a == rd_c);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_FETCH_HI;
        else
            state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FETCH_HI: state_nxt = ST_FETCH_LO;
            ST_FETCH_LO: state_nxt = ST_DECODE;
            ST_DECODE:   state_nxt = ST_EXEC;
            ST_EXEC: begin
                if (op == OP_LDM)
                    state_nxt = ST_LOAD_WB;
                else if (op == OP_HALT)
                    state_nxt = ST_HALT;
                else
                    state_nxt = ST_FETCH_HI;
            end
            ST_LOAD_WB:  state_nxt = ST_FETCH_HI;
            ST_HALT:     state_nxt = ST_HALT;
            default:     state_nxt = ST_FETCH_HI;
        endcase
    end

    // program counter and instruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
            ir <= '0;
        end else begin
            if (state == ST_FETCH_LO)
                ir[INS_W-1:DATA_W] <= mem_rdata;
            if (state == ST_DECODE) begin
                ir[DATA_W-1:0] <= mem_rdata;
                pc             <= pc + ADDR_W'(2);
            end
            if (state == ST_EXEC && jump_take)
                pc <= ADDR_W'(imm);
        end
    end

    // register write-back
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = (op == OP_MOV) ? f_t : f_r;
        rf_wdata = alu_y;
        if (state == ST_LOAD_WB) begin
            rf_we    = 1'b1;
            rf_wdata = mem_rdata;
        end else if (state == ST_EXEC) begin
            case (op)
                OP_LDI, OP_MOV, OP_ADDI, OP_ADDF,
                OP_OR, OP_AND, OP_XOR, OP_ROR: rf_we = 1'b1;
                default:                       rf_we = 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr = pc;
        mem_wr   = 1'b0;
        halted   = 1'b0;
        unique case (state)
            ST_FETCH_LO: mem_addr = pc + ADDR_W'(1);
            ST_EXEC: begin
                if (op == OP_LDM || op == OP_STM)
                    mem_addr = ADDR_W'(imm);
                mem_wr = (op == OP_STM);
            end
            ST_HALT: halted = 1'b1;
            default: ;
        endcase
    end

    assign mem_wdata = rd_a;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE) |=> (pc == $past(pc) + ADDR_W'(2)))
        else $error("pc did not advance by two"); // R1

    AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr)
        else $error("write strobe longer than one cycle"); // R3

    AST_FADD_ZERO_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && op == OP_ADDF && rd_b[DATA_W-2:0] == '0
         && rd_c[DATA_W-2:0] != '0) |-> (fp_sum == rd_c))
        else $error("adding float zero changed the operand"); // R6

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && op == OP_JEQ && rd_a == rd_c)
        |=> (pc == ADDR_W'($past(imm))))
        else $error("taken jump missed its target"); // R9

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(mem_addr)))
        else $error("core left halt"); // R10

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_wr)
        else $error("write while halted"); // R10

endmodule

// File: tb/tb_bytecpu_core.sv
module tb_bytecpu_core;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr;
    logic       mem_wr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic       halted;

    int checks = 0;
    int bad    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytecpu_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // memory attached to the core
    logic [7:0] mem [256];
    always @(posedge clk) begin
        if (mem_wr)
            mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // reference model state
    logic [7:0]  mref  [256];
    logic [7:0]  mregs [16];
    logic [7:0]  mpc;
    logic [15:0] mir;
    int          mph;   // 0 fhi, 1 flo, 2 dec, 3 exe, 4 ldwb, 5 halt

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int fval(input logic [7:0] v);
        int m;
        if (v[6:0] == 7'd0) return 0;
        m = (16 + int'(v[3:0])) << v[6:4];
        return v[7] ? -m : m;
    endfunction

    // float sum per R6: exact, truncated to five significant bits
    function automatic logic [7:0] fadd_ref(input logic [7:0] a, input logic [7:0] b);
        int s, mag, p, e, man;
        logic ng;
        s   = fval(a) + fval(b);
        ng  = (s < 0);
        mag = ng ? -s : s;
        if (mag < 16) return 8'h00;
        p = 0;
        while ((mag >> (p + 1)) != 0) p++;
        e = p - 4;
        if (e > 7) return {ng, 7'h7F};
        man = (mag >> e) & 15;
        if (e == 0 && man == 0) return 8'h00;
        return {ng, 3'(e), 4'(man)};
    endfunction

    function automatic string tag_for(input int ph, input logic [3:0] opc);
        if (ph < 3) return "R1";
        if (ph == 4) return "R3";
        if (ph == 5) return "R10";
        case (opc)
            4'h1, 4'h2, 4'h3: return "R3";
            4'h4: return "R4";
            4'h5: return "R5";
            4'h6: return "R6";
            4'h7, 4'h8, 4'h9: return "R7";
            4'hA: return "R8";
            4'hB: return "R9";
            4'hC: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic compare_cycle();
        logic [7:0] e_addr;
        logic       e_wr;
        logic [7:0] e_wd;
        string      tg;
        e_addr = mpc;
        e_wr   = 1'b0;
        e_wd   = 8'h00;
        if (mph == 1) e_addr = mpc + 8'd1;
        if (mph == 3) begin
            if (mir[15:12] == 4'h1) e_addr = mir[7:0];
            if (mir[15:12] == 4'h3) begin
                e_addr = mir[7:0];
                e_wr   = 1'b1;
                e_wd   = mregs[mir[11:8]];
            end
        end
        tg = tag_for(mph, mir[15:12]);
        chk(tg, "mem_addr", mem_addr, e_addr);
        chk(tg, "mem_wr", {7'd0, mem_wr}, {7'd0, e_wr});
        chk(tg, "halted", {7'd0, halted}, {7'd0, (mph == 5)});
        if (e_wr) chk(tg, "mem_wdata", mem_wdata, e_wd);
    endtask

    task automatic advance();
        logic [3:0] opc, r, s, t;
        logic [7:0] xy, v;
        opc = mir[15:12]; r = mir[11:8]; s = mir[7:4]; t = mir[3:0]; xy = mir[7:0];
        case (mph)
            0: mph = 1;
            1: begin mir[15:8] = mref[mpc]; mph = 2; end
            2: begin mir[7:0] = mref[mpc + 8'd1]; mpc = mpc + 8'd2; mph = 3; end
            3: begin
                mph = 0;
                case (opc)
                    4'h1: mph = 4;
                    4'h2: mregs[r] = xy;
                    4'h3: mref[xy] = mregs[r];
                    4'h4: mregs[t] = mregs[s];
                    4'h5: mregs[r] = mregs[s] + mregs[t];
                    4'h6: mregs[r] = fadd_ref(mregs[s], mregs[t]);
                    4'h7: mregs[r] = mregs[s] | mregs[t];
                    4'h8: mregs[r] = mregs[s] & mregs[t];
                    4'h9: mregs[r] = mregs[s] ^ mregs[t];
                    4'hA: begin
                        v = mregs[r];
                        for (int k = 0; k < int'(t); k++) v = {v[0], v[7:1]};
                        mregs[r] = v;
                    end
                    4'hB: if (mregs[r] == mregs[0]) mpc = xy;
                    4'hC: mph = 5;
                    default: ;
                endcase
            end
            4: begin mregs[mir[11:8]] = mref[mir[7:0]]; mph = 0; end
            default: mph = 5;
        endcase
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'h00;
            mref[i] = 8'h00;
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        mem[a]  = d;
        mref[a] = d;
    endtask

    task automatic put(input logic [7:0] a, input logic [15:0] w);
        poke(a, w[15:8]);
        poke(a + 8'd1, w[7:0]);
    endtask

    task automatic run_prog(input int limit);
        int cyc, extra;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        mpc = 8'h00; mir = 16'h0000; mph = 0;
        for (int i = 0; i < 16; i++) mregs[i] = 8'h00;
        rst_n = 1'b1;
        chk("R2", "halted after reset", {7'd0, halted}, 8'h00);
        chk("R2", "first address", mem_addr, 8'h00);
        cyc = 0; extra = 0;
        while (extra < 10) begin
            compare_cycle();
            advance();
            @(negedge clk);
            cyc++;
            if (mph == 5) extra++;
            if (cyc > limit) begin
                checks++; bad++;
                $display("FAIL R1 watchdog: actual %0d cycles expected at most %0d", cyc, limit);
                break;
            end
        end
    endtask

    logic [7:0] fa [8] = '{8'h40, 8'h48, 8'h7F, 8'h45, 8'h00, 8'h12, 8'h4F, 8'hC8};
    logic [7:0] fb [8] = '{8'h40, 8'hC0, 8'h7F, 8'hC5, 8'h37, 8'h91, 8'h01, 8'h40};
    logic [7:0] fe [8] = '{8'h50, 8'h30, 8'h7F, 8'h00, 8'h37, 8'h00, 8'h50, 8'hB0};

    initial begin
        // program 1: loads, logic, add wrap, copies, no-ops
        clear_mem();
        poke(8'hF0, 8'h3C);
        put(8'h00, 16'h217F); put(8'h02, 16'h2285); put(8'h04, 16'h5312);
        put(8'h06, 16'h7412); put(8'h08, 16'h8512); put(8'h0A, 16'h9612);
        put(8'h0C, 16'h4017); put(8'h0E, 16'h18F0);
        put(8'h10, 16'hD123); put(8'h12, 16'h0FFF); put(8'h14, 16'hE000);
        put(8'h16, 16'hF0E7); put(8'h18, 16'h4F1A);
        put(8'h1A, 16'h33E0); put(8'h1C, 16'h34E1); put(8'h1E, 16'h35E2);
        put(8'h20, 16'h36E3); put(8'h22, 16'h37E4); put(8'h24, 16'h38E5);
        put(8'h26, 16'h39E6); put(8'h28, 16'h3AE7); put(8'h2A, 16'h31E8);
        put(8'h2C, 16'h32E9); put(8'h2E, 16'hC000);
        run_prog(400);
        chk("R5",  "7F+85 wraps", mem[8'hE0], 8'h04);
        chk("R7",  "OR",          mem[8'hE1], 8'hFF);
        chk("R7",  "AND",         mem[8'hE2], 8'h05);
        chk("R7",  "XOR",         mem[8'hE3], 8'hFA);
        chk("R4",  "copy",        mem[8'hE4], 8'h7F);
        chk("R3",  "memory load", mem[8'hE5], 8'h3C);
        chk("R2",  "untouched register is zero", mem[8'hE6], 8'h00);
        chk("R4",  "copy ignores bits 11:8", mem[8'hE7], 8'h7F);
        chk("R11", "no-ops keep R1", mem[8'hE8], 8'h7F);
        chk("R11", "no-ops keep R2", mem[8'hE9], 8'h85);

        // program 2: rotations and jumps
        clear_mem();
        put(8'h00, 16'h2196); put(8'h02, 16'hA103); put(8'h04, 16'h31E0);
        put(8'h06, 16'h225A); put(8'h08, 16'hA200); put(8'h0A, 16'h32E1);
        put(8'h0C, 16'h2381); put(8'h0E, 16'hA30B); put(8'h10, 16'h33E2);
        put(8'h12, 16'h2481); put(8'h14, 16'hA408); put(8'h16, 16'h34E3);
        put(8'h18, 16'h2077); put(8'h1A, 16'h2577); put(8'h1C, 16'h2644);
        put(8'h1E, 16'hB624); put(8'h20, 16'h2701); put(8'h22, 16'hB52A);
        put(8'h24, 16'h2702); put(8'h26, 16'hC000); put(8'h28, 16'hC000);
        put(8'h2A, 16'hB030); put(8'h2C, 16'h27FF); put(8'h2E, 16'hC000);
        put(8'h30, 16'h37E4); put(8'h32, 16'hC000);
        run_prog(400);
        chk("R8",  "ror 3",  mem[8'hE0], 8'hD2);
        chk("R8",  "ror 0",  mem[8'hE1], 8'h5A);
        chk("R8",  "ror 11", mem[8'hE2], 8'h30);
        chk("R8",  "ror 8",  mem[8'hE3], 8'h81);
        chk("R9",  "jump path", mem[8'hE4], 8'h01);
        chk("R10", "halted flag", {7'd0, halted}, 8'h01);
        chk("R10", "halt address", mem_addr, 8'h34);

        // program 3: float additions
        clear_mem();
        for (int i = 0; i < 8; i++) begin
            put(8'(8 * i),     {8'h21, fa[i]});
            put(8'(8 * i + 2), {8'h22, fb[i]});
            put(8'(8 * i + 4), 16'h6312);
            put(8'(8 * i + 6), {8'h33, 8'(8'hE0 + i)});
        end
        put(8'h40, 16'hC000);
        run_prog(600);
        for (int i = 0; i < 8; i++)
            chk("R6", $sformatf("float pair %0d", i), mem[8'(8'hE0 + i)], fe[i]);

        // program 4: store rewrites the next instruction into a halt
        clear_mem();
        put(8'h00, 16'h21C0); put(8'h02, 16'h2A11); put(8'h04, 16'h2B22);
        put(8'h06, 16'h3108); put(8'h08, 16'h2555); put(8'h0A, 16'h3AF0);
        put(8'h0C, 16'hC000);
        run_prog(200);
        chk("R12", "rewritten byte", mem[8'h08], 8'hC0);
        chk("R12", "store after rewrite skipped", mem[8'hF0], 8'h00);
        chk("R10", "halt address after rewrite", mem_addr, 8'h0A);

        // program 5: pseudo-random sequence, full memory compared
        clear_mem();
        for (int i = 8'h80; i < 8'hC0; i++) poke(8'(i), 8'($urandom_range(0, 255)));
        for (int i = 0; i < 40; i++) begin
            logic [3:0]  opc;
            logic [15:0] w;
            case ($urandom_range(0, 8))
                0: opc = 4'h1; 1: opc = 4'h2; 2: opc = 4'h4; 3: opc = 4'h5;
                4: opc = 4'h6; 5: opc = 4'h7; 6: opc = 4'h8; 7: opc = 4'h9;
                default: opc = 4'hA;
            endcase
            w = {opc, 4'($urandom_range(0, 15)), 8'($urandom_range(0, 255))};
            if (opc == 4'h1) w[7:6] = 2'b10;
            put(8'(2 * i), w);
        end
        for (int r = 0; r < 16; r++) put(8'(8'h50 + 2 * r), {4'h3, 4'(r), 8'(8'hC0 + r)});
        put(8'h70, 16'hC000);
        run_prog(2000);
        for (int i = 0; i < 256; i++)
            chk("R12", $sformatf("memory byte %0h", i), mem[i], mref[i]);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule